// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the counting logic of an integer-N feedback path. It runs on the output clock of an external dual-modulus prescaler and tells that prescaler, through a modulus-control line, whether the next cycle is a long one or a short one. The prescaler divides by P+1 when the line is high and by P when it is low. One output period lasts B prescaler cycles. The first A of them are long. The total division from the oscillator to the divided pulse is therefore N = P·B + A.

The modulus pair is chosen by software from two options. One pair is 16/17, which gives a ratio range of 256 to 65551. The other pair is 19/20, which gives a range of 361 to 77836. The swallow count is 5 bits wide and the main count is 12 bits wide. The block samples a new swallow count, main count and pair selection only when an output period ends, so no period ever mixes two settings. A combinational flag reports whether the settings on the inputs give a contiguous, legal ratio.

Top module: `pswDivider`

## Requirements
- R1: While rstN is low, modCtl, divPulse and presMode are 0. The first period starts at the first rising clkIn edge after release, so divPulse is first high in the B-th cycle after release.
- R2: divPulse is high for exactly one clkIn cycle per output period, in the last cycle. A period lasts exactly B clkIn cycles.
- R3: For A ≤ B, modCtl is high during the first A clkIn cycles of each period and low for the rest of the period.
- R4: Take a prescaler that spends P+1 input cycles on a clkIn cycle when modCtl is high and P cycles when it is low. P is 16 when presMode is 0 and 19 when presMode is 1. That prescaler then spends exactly P·B + A input cycles per output period.
- R5: swallowA, mainB and modeSel are sampled only at the clock edge that ends a period. A change in the middle of a period leaves that period unaltered and takes effect in the next period.
- R6: presMode carries the modeSel value loaded at the start of the current period and stays constant throughout that period.
- R7: cfgValid is 1 exactly when mainB ≥ swallowA and mainB ≥ P. P is 16 for modeSel = 0 and 19 for modeSel = 1.
- R8: The ratio extremes are reached. They are 256 (A=0, B=16) and 65551 (A=31, B=4095) with modeSel = 0, and 361 (A=0, B=19) and 77836 (A=31, B=4095) with modeSel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Prescaler output clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swallowA | input | 5 | Number of long (P+1) cycles per period |
| mainB | input | 12 | Total prescaler cycles per period |
| modeSel | input | 1 | Modulus pair select: 0 = 16/17, 1 = 19/20 |
| modCtl | output | 1 | Prescaler modulus control, 1 = divide by P+1 |
| presMode | output | 1 | Pair selection in force for the current period |
| divPulse | output | 1 | One-cycle pulse in the last cycle of each period |
| cfgValid | output | 1 | Input settings form a legal contiguous ratio |

## Verification
The assertions assume that swallowA, mainB and modeSel are stable around each rising clkIn edge. The single-pulse property also assumes that the main count is not 1, because with B=1 every cycle would legitimately carry a pulse. The stimulus changes inputs only half a cycle away from the rising edge and never loads a main count below the prescaler modulus. Settings that break the validity rule appear on the inputs only briefly within a low clock phase. During that time only cfgValid is inspected, so they are never loaded.

// File: rtl/pswPkg.sv
package pswPkg;
  // Strobes from the control unit to the counting datapath
  typedef struct packed {
    logic reload;  // period ends: take new settings, restart counts
    logic step;    // ordinary cycle: advance counts
  } pswStrobeT;
endpackage

// File: rtl/pswDatapath.sv
module pswDatapath
  import pswPkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  pswStrobeT       strb,
  input  logic [A_W-1:0]  swallowA,
  input  logic [B_W-1:0]  mainB,
  input  logic            modeSel,
  output logic [B_W-1:0]  mainCnt,
  output logic [A_W-1:0]  swallowCnt,
  output logic            actMode
);
  localparam logic [B_W-1:0] MAIN_ONE = B_W'(1);
  localparam logic [A_W-1:0] SWAL_ONE = A_W'(1);

  // mainCnt: cycles left in the period including the current one
  // swallowCnt: long cycles left including the current one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt    <= '0;
      swallowCnt <= '0;
      actMode    <= 1'b0;
    end else if (strb.reload) begin
      mainCnt    <= mainB;
      swallowCnt <= swallowA;
      actMode    <= modeSel;
    end else if (strb.step) begin
      mainCnt <= mainCnt - MAIN_ONE;
      if (swallowCnt != '0) swallowCnt <= swallowCnt - SWAL_ONE;
    end
  end

  // R2
  mainstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> mainCnt == $past(mainCnt) - MAIN_ONE);

  // R5
  modehold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reload |=> $stable(actMode));
endmodule

// File: rtl/pswControl.sv
module pswControl
  import pswPkg::*;
#(
  parameter int A_W  = 5,
  parameter int B_W  = 12,
  parameter int P_LO = 16,
  parameter int P_HI = 19
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [B_W-1:0]  mainCnt,
  input  logic [A_W-1:0]  swallowCnt,
  input  logic [A_W-1:0]  swallowA,
  input  logic [B_W-1:0]  mainB,
  input  logic            modeSel,
  output pswStrobeT       strb,
  output logic            modCtl,
  output logic            divPulse,
  output logic            cfgValid
);
  localparam logic [B_W-1:0] MAIN_ONE = B_W'(1);
  localparam logic [B_W-1:0] MAIN_TWO = B_W'(2);
  localparam logic [A_W-1:0] SWAL_ONE = A_W'(1);
  localparam logic [B_W-1:0] PMIN_LO  = B_W'(P_LO);
  localparam logic [B_W-1:0] PMIN_HI  = B_W'(P_HI);

  logic           lastNow;
  logic [B_W-1:0] swallowWide;
  logic [B_W-1:0] pMin;

  // counts at 0 (after reset) or 1 (last cycle) both end the period
  assign lastNow     = (mainCnt <= MAIN_ONE);
  assign strb.reload = lastNow;
  assign strb.step   = !lastNow;

  // Outputs are registered from the next-state view so the prescaler
  // sees clean flop outputs with no decode glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modCtl   <= 1'b0;
      divPulse <= 1'b0;
    end else if (lastNow) begin
      modCtl   <= (swallowA != '0);
      divPulse <= (mainB == MAIN_ONE);
    end else begin
      modCtl   <= (swallowCnt > SWAL_ONE);
      divPulse <= (mainCnt == MAIN_TWO);
    end
  end

  assign swallowWide = {{(B_W-A_W){1'b0}}, swallowA};
  assign pMin        = modeSel ? PMIN_HI : PMIN_LO;
  assign cfgValid    = (mainB >= swallowWide) && (mainB >= pMin);

  // R3
  modctl_swallow_chk: assert property (@(posedge clk) disable iff (!rstN)
    modCtl == (swallowCnt != '0));

  // R2
  pulse_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse == (mainCnt == MAIN_ONE));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divPulse && (mainB != MAIN_ONE)) |=> !divPulse);
endmodule

// File: rtl/pswDivider.sv
module pswDivider
  import pswPkg::*;
#(
  parameter int A_W  = 5,
  parameter int B_W  = 12,
  parameter int P_LO = 16,
  parameter int P_HI = 19
) (
  input  logic            clkIn,
  input  logic            rstN,
  input  logic [A_W-1:0]  swallowA,
  input  logic [B_W-1:0]  mainB,
  input  logic            modeSel,
  output logic            modCtl,
  output logic            presMode,
  output logic            divPulse,
  output logic            cfgValid
);
  pswStrobeT      strb;
  logic [B_W-1:0] mainCnt;
  logic [A_W-1:0] swallowCnt;

  pswControl #(.A_W(A_W), .B_W(B_W), .P_LO(P_LO), .P_HI(P_HI)) uCtrl (
    .clk        (clkIn),
    .rstN       (rstN),
    .mainCnt    (mainCnt),
    .swallowCnt (swallowCnt),
    .swallowA   (swallowA),
    .mainB      (mainB),
    .modeSel    (modeSel),
    .strb       (strb),
    .modCtl     (modCtl),
    .divPulse   (divPulse),
    .cfgValid   (cfgValid)
  );

  pswDatapath #(.A_W(A_W), .B_W(B_W)) uPath (
    .clk        (clkIn),
    .rstN       (rstN),
    .strb       (strb),
    .swallowA   (swallowA),
    .mainB      (mainB),
    .modeSel    (modeSel),
    .mainCnt    (mainCnt),
    .swallowCnt (swallowCnt),
    .actMode    (presMode)
  );
endmodule

// File: tb/tb_pswDivider.sv
module tb_pswDivider;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    int a; int b; int m; int expN; int expV;
  } vecT;

  // expN = 0 marks an illegal setting: only cfgValid is inspected
  localparam vecT VECS [NVEC] = '{
    '{0, 16, 0, 256, 1},
    '{31, 4095, 0, 65551, 1},
    '{0, 19, 1, 361, 1},
    '{31, 4095, 1, 77836, 1},
    '{5, 20, 0, 325, 1},
    '{20, 19, 0, 0, 0},
    '{7, 100, 1, 1907, 1},
    '{0, 18, 1, 0, 0},
    '{16, 16, 0, 272, 1},
    '{0, 15, 0, 0, 0},
    '{3, 40, 1, 763, 1},
    '{0, 16, 1, 0, 0},
    '{1, 17, 0, 273, 1}
  };

  logic       clkIn = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] swallowA = '0;
  logic [11:0] mainB = 12'd16;
  logic       modeSel = 1'b0;
  logic       modCtl, presMode, divPulse, cfgValid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  pswDivider dut (
    .clkIn(clkIn), .rstN(rstN), .swallowA(swallowA), .mainB(mainB),
    .modeSel(modeSel), .modCtl(modCtl), .presMode(presMode),
    .divPulse(divPulse), .cfgValid(cfgValid)
  );

  always #(CLK_PERIOD/2) clkIn = ~clkIn;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic syncPulse();
    for (int k = 0; k < 6000; k++) begin
      @(negedge clkIn);
      if (divPulse) return;
    end
    check(1'b0, "R2 no pulse seen", 0, 1);
  endtask

  // Walk one period; the prescaler model adds P or P+1 input cycles per
  // clkIn cycle. Optionally drives new settings after cycle chgAt.
  task automatic measure(input int expMode, input int chgAt,
                         input int nA, input int nB, input int nM,
                         output int nCyc, output int nSw,
                         output int ratio, output int modeErr);
    nCyc = 0; nSw = 0; ratio = 0; modeErr = 0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clkIn);
      nCyc++;
      if (modCtl) nSw++;
      ratio += (presMode ? 19 : 16) + (modCtl ? 1 : 0);
      if (int'(presMode) != expMode) modeErr++;
      if (k == chgAt) begin
        swallowA = 5'(nA); mainB = 12'(nB); modeSel = nM[0];
      end
      if (divPulse) return;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nCyc, nSw, ratio, modeErr, k;

    // R1: reset state and first period after release
    swallowA = 5'd2; mainB = 12'd20; modeSel = 1'b1;
    repeat (3) @(negedge clkIn);
    check(modCtl == 1'b0, "R1 modCtl in reset", int'(modCtl), 0);
    check(divPulse == 1'b0, "R1 divPulse in reset", int'(divPulse), 0);
    check(presMode == 1'b0, "R1 presMode in reset", int'(presMode), 0);
    rstN = 1'b1;
    k = 0;
    for (int i = 1; i <= 6000; i++) begin
      @(negedge clkIn);
      if (i == 1) check(presMode == 1'b1, "R6 mode loaded at first edge", int'(presMode), 1);
      if (divPulse) begin k = i; break; end
    end
    check(k == 20, "R1 first pulse cycle", k, 20);

    // Vector walk: R2 R3 R4 R6 R7 R8
    foreach (VECS[i]) begin
      swallowA = 5'(VECS[i].a); mainB = 12'(VECS[i].b); modeSel = VECS[i].m[0];
      #1;
      check(int'(cfgValid) == VECS[i].expV, "R7 cfgValid", int'(cfgValid), VECS[i].expV);
      if (VECS[i].expN != 0) begin
        syncPulse();
        measure(VECS[i].m, -1, 0, 0, 0, nCyc, nSw, ratio, modeErr);
        check(nCyc == VECS[i].b, "R2 period length", nCyc, VECS[i].b);
        check(nSw == VECS[i].a, "R3 long cycles", nSw, VECS[i].a);
        check(ratio == VECS[i].expN, "R4 R8 total ratio", ratio, VECS[i].expN);
        check(modeErr == 0, "R6 presMode steady", modeErr, 0);
      end
    end

    // R5: settings changed mid-period apply only from the next period
    swallowA = 5'd4; mainB = 12'd30; modeSel = 1'b0;
    syncPulse();
    measure(0, 5, 9, 50, 1, nCyc, nSw, ratio, modeErr);
    check(nCyc == 30, "R5 old length kept", nCyc, 30);
    check(nSw == 4, "R5 old swallow kept", nSw, 4);
    check(ratio == 484, "R5 old ratio kept", ratio, 484);
    check(modeErr == 0, "R6 mode unchanged mid-period", modeErr, 0);
    measure(1, -1, 0, 0, 0, nCyc, nSw, ratio, modeErr);
    check(nCyc == 50, "R5 new length", nCyc, 50);
    check(nSw == 9, "R5 new swallow", nSw, 9);
    check(ratio == 959, "R5 new ratio", ratio, 959);
    check(modeErr == 0, "R6 new mode in force", modeErr, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule